// File: doc/BRIEF.md
# DMA Minor-Loop Bandwidth Throttle

This block sits between the minor-loop sequencer of a DMA engine and the logic that raises bus requests. It can slow the engine down on purpose. After each read or write beat completes, it can hold back the next access for a fixed number of idle cycles. A two-bit throttle code selects the idle count: none, four or eight cycles.

The sequencer sends one pulse for each completed beat. With that pulse it marks whether the beat was the first transfer of the minor loop or the last write of the minor loop. It also says whether the source and destination transfer sizes match. When the sizes match, the stall after the first transfer and the stall after the last write are both skipped, which keeps start-up latency low. The single output is a grant. The sequencer may start its next access only while the grant is high.

An abort input, or the synchronous active-low reset, drops any stall in progress at once.

Top module: `bw_throttle`

## Requirements
- R1: While reset is held low and on the cycle after reset, `grant_o` is 1.
- R2: With throttle code 2'b00, a beat-done pulse leaves `grant_o` at 1 on every following cycle.
- R3: Throttle code 2'b01 is reserved and behaves exactly as 2'b00: a beat-done pulse causes no stall.
- R4: With throttle code 2'b10, a beat-done pulse sampled at a clock edge drives `grant_o` to 0 for exactly 4 cycles after that edge. `grant_o` is 1 again on the fifth cycle.
- R5: With throttle code 2'b11, a beat-done pulse drives `grant_o` to 0 for exactly 8 cycles after the sampling edge.
- R6: When `size_eq_i` is 1 and `first_beat_i` is 1 with the beat-done pulse, no stall is inserted, whatever the throttle code.
- R7: When `size_eq_i` is 1 and `last_write_i` is 1 with the beat-done pulse, no stall is inserted, whatever the throttle code.
- R8: When `size_eq_i` is 0, the first-beat and last-write markers have no effect, and the stall length follows the throttle code.
- R9: `abort_i` high at a clock edge ends any stall, so `grant_o` is 1 on the next cycle. An abort takes priority over a beat-done pulse at the same edge.
- R10: A beat-done pulse that arrives during a stall restarts the stall at the full length for the current code. A zero length, from the code or from an exemption, ends the stall at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| abort_i | input | 1 | Cancel any stall in progress |
| bw_code_i | input | 2 | Throttle code: 00 none, 01 reserved (none), 10 four cycles, 11 eight cycles |
| size_eq_i | input | 1 | Source and destination transfer sizes are equal |
| beat_done_i | input | 1 | One-cycle pulse: a read or write beat has completed |
| first_beat_i | input | 1 | The completing beat is the first transfer of the minor loop |
| last_write_i | input | 1 | The completing beat is the last write of the minor loop |
| grant_o | output | 1 | Next access may be issued |

## Verification
The bench measures the exact length of each low run of the grant, for both stalling codes. An off-by-one in loading or decrementing the counter therefore shows up as a run of 3 or 5 cycles, or 7 or 9, and the check fails. The reserved code is exercised on its own, so a decoder that maps it to a stall is caught.

The exemption cases are paired with the same markers under unequal sizes. A design that ignored the size-equality condition, or that exempted on the wrong marker, would stall where it should not, or skip where it should stall. Abort is checked alone and together with a beat-done pulse at the same edge, and a second pulse is sent mid-stall to confirm that the count restarts rather than continues.

// File: rtl/bw_throttle_pkg.sv
// Package: shared types and constants for the bandwidth throttle.
// Assumes a two-bit throttle code; stall lengths are parameters of the top.
package bw_throttle_pkg;

    // Throttle code values as presented by the configuration source.
    typedef enum logic [1:0] {
        BW_NONE = 2'b00,
        BW_RSVD = 2'b01,
        BW_MID  = 2'b10,
        BW_HIGH = 2'b11
    } bw_code_e;

    // Width needed for a down-counter that must hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bw_len_decode.sv
// Module: bw_len_decode
// Maps the throttle code to a stall length in cycles. The reserved code
// is treated as "no stall". Purely combinational.
// Assumes STALL_MID and STALL_HIGH both fit in CNT_W bits.
module bw_len_decode
    import bw_throttle_pkg::*;
#(
    parameter int STALL_MID  = 4,
    parameter int STALL_HIGH = 8,
    parameter int CNT_W      = cnt_width(STALL_HIGH)
) (
    input  logic [1:0]       code_i,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] LEN_MID  = CNT_W'(STALL_MID);
    localparam logic [CNT_W-1:0] LEN_HIGH = CNT_W'(STALL_HIGH);

    // Select the stall length for the current code.
    always_comb begin
        unique case (bw_code_e'(code_i))
            BW_MID:  len_o = LEN_MID;
            BW_HIGH: len_o = LEN_HIGH;
            default: len_o = '0;   // none and reserved both mean no stall
        endcase
    end

endmodule

// File: rtl/bw_exempt.sv
// Module: bw_exempt
// Decides whether the completing beat is excused from stalling. With equal
// source/destination sizes, the first transfer and the last write skip
// the stall. Optionally registered-free; combinational only.
// Assumes markers are valid only together with the beat-done pulse.
module bw_exempt #(
    parameter bit EXEMPT_EN = 1'b1
) (
    input  logic size_eq_i,
    input  logic first_beat_i,
    input  logic last_write_i,
    output logic skip_o
);

    generate
        if (EXEMPT_EN) begin : g_exempt
            // Skip the stall when sizes match and the beat is at a loop edge.
            always_comb skip_o = size_eq_i & (first_beat_i | last_write_i);
        end else begin : g_no_exempt
            // Exemption disabled: every beat stalls per the code.
            always_comb skip_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bw_stall_cnt.sv
// Module: bw_stall_cnt
// Down-counter that holds off the sequencer. A load pulse writes the
// stall length (possibly zero); the counter then counts down to zero.
// Abort and reset clear it. Grant is high exactly while the count is zero.
// Assumes a synchronous active-low reset.
module bw_stall_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             idle_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counter update: reset/clear first, then load, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Idle whenever no stall cycles remain.
    always_comb idle_o = (cnt_q == '0);

    // R1: the counter is empty the cycle after reset.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

    // R4/R5: an active stall counts down by one when nothing else acts.
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load_i && !clear_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9: clearing always leaves the counter empty.
    a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R10: a load writes the requested length.
    a_r10_load_len: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cnt_q == $past(len_i)));

endmodule

// File: rtl/bw_throttle.sv
// Module: bw_throttle (top)
// Inserts idle cycles after each completed beat of a DMA minor loop so the
// engine consumes less bus bandwidth. Grant low means "do not issue".
// Assumes beat_done_i is a one-cycle pulse and the markers are qualified by it.
module bw_throttle
    import bw_throttle_pkg::*;
#(
    parameter int STALL_MID  = 4,
    parameter int STALL_HIGH = 8,
    parameter bit EXEMPT_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort_i,
    input  logic [1:0] bw_code_i,
    input  logic       size_eq_i,
    input  logic       beat_done_i,
    input  logic       first_beat_i,
    input  logic       last_write_i,
    output logic       grant_o
);

    localparam int CNT_W = cnt_width(STALL_HIGH);

    logic [CNT_W-1:0] code_len;
    logic [CNT_W-1:0] load_len;
    logic             skip;
    logic             idle;

    bw_len_decode #(
        .STALL_MID (STALL_MID),
        .STALL_HIGH(STALL_HIGH),
        .CNT_W     (CNT_W)
    ) u_decode (
        .code_i(bw_code_i),
        .len_o (code_len)
    );

    bw_exempt #(
        .EXEMPT_EN(EXEMPT_EN)
    ) u_exempt (
        .size_eq_i   (size_eq_i),
        .first_beat_i(first_beat_i),
        .last_write_i(last_write_i),
        .skip_o      (skip)
    );

    // Exempt beats load a zero length, which ends any stall.
    always_comb load_len = skip ? '0 : code_len;

    bw_stall_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(abort_i),
        .load_i (beat_done_i),
        .len_i  (load_len),
        .idle_o (idle)
    );

    // Grant follows the counter being empty.
    always_comb grant_o = idle;

    // R2/R3: codes with a clear upper bit never stall.
    a_r2_r3_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done_i && !bw_code_i[1]) |=> grant_o);

    // R4/R5: a non-exempt done with a stalling code drops the grant.
    a_r4_r5_stall_start: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done_i && bw_code_i[1] && !abort_i &&
         !(size_eq_i && (first_beat_i || last_write_i))) |=> !grant_o);

    // R6/R7: exempt beats never stall.
    a_r6_r7_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done_i && size_eq_i && (first_beat_i || last_write_i)) |=> grant_o);

    // R9: abort restores the grant on the next cycle.
    a_r9_abort_grant: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> grant_o);

endmodule

// File: tb/sim_bw_throttle.sv
module sim_bw_throttle;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       abort_i;
    logic [1:0] bw_code_i;
    logic       size_eq_i;
    logic       beat_done_i;
    logic       first_beat_i;
    logic       last_write_i;
    logic       grant_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    bw_throttle u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort_i     (abort_i),
        .bw_code_i   (bw_code_i),
        .size_eq_i   (size_eq_i),
        .beat_done_i (beat_done_i),
        .first_beat_i(first_beat_i),
        .last_write_i(last_write_i),
        .grant_o     (grant_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge only.
    task automatic idle_inputs();
        abort_i = 0; beat_done_i = 0; first_beat_i = 0; last_write_i = 0;
    endtask

    // Pulse beat-done for one cycle; returns at the falling edge after the sampling edge.
    task automatic pulse_done(input logic [1:0] code, input bit eq, input bit first, input bit last);
        @(negedge clk);
        bw_code_i = code; size_eq_i = eq; first_beat_i = first; last_write_i = last;
        beat_done_i = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    // Count consecutive low-grant cycles, starting at the current falling edge.
    task automatic low_run(output int n);
        n = 0;
        while (grant_o == 1'b0 && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_stall(input logic [1:0] code, input bit eq, input bit first,
                           input bit last, input int exp, input string req);
        int n;
        pulse_done(code, eq, first, last);
        low_run(n);
        check(n == exp, req, n, exp);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0;
        #1 check(grant_o == 1'b1, "R1 grant during reset", grant_o, 1);
        @(negedge clk);
        rst_n = 1;
        check(grant_o == 1'b1, "R1 grant after reset", grant_o, 1);
    endtask

    task automatic t_abort();
        pulse_done(2'b11, 0, 0, 0);
        @(negedge clk);
        check(grant_o == 1'b0, "R9 stall before abort", grant_o, 0);
        abort_i = 1;
        @(negedge clk);
        abort_i = 0;
        check(grant_o == 1'b1, "R9 abort ends stall", grant_o, 1);
        // Abort together with a done pulse: the abort wins.
        @(negedge clk);
        bw_code_i = 2'b11; size_eq_i = 0; beat_done_i = 1; abort_i = 1;
        @(negedge clk);
        idle_inputs();
        check(grant_o == 1'b1, "R9 abort beats done", grant_o, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reload();
        int n;
        pulse_done(2'b10, 0, 0, 0);
        @(negedge clk);           // two stall cycles observed so far
        beat_done_i = 1; bw_code_i = 2'b10;
        @(negedge clk);
        idle_inputs();
        low_run(n);
        check(n == 4, "R10 reload full length", n, 4);
        // Zero-length load during a stall ends it at once.
        pulse_done(2'b11, 0, 0, 0);
        @(negedge clk);
        beat_done_i = 1; bw_code_i = 2'b00;
        @(negedge clk);
        idle_inputs();
        check(grant_o == 1'b1, "R10 zero reload ends stall", grant_o, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_mid_stall();
        pulse_done(2'b11, 0, 0, 0);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(grant_o == 1'b1, "R1 reset clears stall", grant_o, 1);
    endtask

    initial begin
        rst_n = 0; bw_code_i = 2'b00; size_eq_i = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_stall(2'b00, 0, 0, 0, 0, "R2 code 00 no stall");
        t_stall(2'b01, 0, 0, 0, 0, "R3 reserved code no stall");
        t_stall(2'b10, 0, 0, 0, 4, "R4 code 10 four cycles");
        t_stall(2'b11, 0, 0, 0, 8, "R5 code 11 eight cycles");
        t_stall(2'b11, 1, 0, 0, 8, "R5 equal sizes mid-loop still stalls");
        t_stall(2'b11, 1, 1, 0, 0, "R6 first beat exempt");
        t_stall(2'b10, 1, 1, 0, 0, "R6 first beat exempt code 10");
        t_stall(2'b11, 1, 0, 1, 0, "R7 last write exempt");
        t_stall(2'b10, 1, 0, 1, 0, "R7 last write exempt code 10");
        t_stall(2'b11, 0, 1, 0, 8, "R8 first marker unequal sizes");
        t_stall(2'b10, 0, 0, 1, 4, "R8 last marker unequal sizes");
        t_abort();
        t_reload();
        t_reset_mid_stall();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule